// File: doc/BRIEF.md
# Serial Register Access Frontend

This block lets a host processor reach a small bank of 16-bit configuration registers over a four-wire serial link. The link runs in clock mode 3: the serial clock idles high, the block samples its input on rising edges and changes its output on falling edges. While chip select is low, the host shifts in 16-bit frames, most significant bit first. Each frame holds a direction flag, a 7-bit byte address and one data byte. Every register is split into two byte addresses, and a write frame changes only the byte it names.

Reads are pipelined. A read frame names a byte address, and the whole 16-bit register that holds that byte is shifted back to the host during the next frame. That next frame can carry a new request, so reads stream with no gap between frames. One address is reserved for a command register that is never stored. If a write to that address sets the capture bit, the block emits a single-cycle capture-start pulse and raises a busy flag. The capture logic clears the flag when it reports completion.

The serial clock runs far slower than the system clock. All serial inputs are synchronised into the system clock domain, and edges are detected there.

Top module: `sreg_frontend`

## Requirements
- R1: A frame is 16 bits, sampled on rising serial-clock edges while chip select (active low) is low, MSB first. Frame bit 15 is the direction flag (1 = write), bits 14..8 are the byte address, and bits 7..0 are the data byte.
- R2: A write frame to byte address a, with a below 2*NUM_REGS, stores the data byte in that byte. An even address is the low half of register a/2 and an odd address is the high half. The other half keeps its value.
- R3: A read frame (flag 0) to a mapped address makes the next frame shift out {byte 2r+1, byte 2r} with r = a/2. The bits come out MSB first and change on falling serial-clock edges. The data bits of the read frame are ignored.
- R4: A frame that returns read data may itself carry a new read request, so consecutive read frames stream continuously.
- R5: A read request to an address of 2*NUM_REGS or higher returns 0x0000 in the next frame. This includes the command register addresses.
- R6: The frame that follows a write frame returns 0x0000.
- R7: A complete write frame to CMD_ADDR (default 0x3F) with data bit CMD_BIT (default 3) set, that is frame 0xBF08, gives exactly one capt_start_o pulse one clock wide. Every other frame, including a write of 0x08 to address 0x3E and a write of 0x00 to 0x3F, gives no pulse.
- R8: busy_o goes high in the cycle after a capt_start_o pulse. It goes low after capt_done_i is seen while no pulse is present. If a pulse and capt_done_i arrive in the same cycle, busy_o stays high.
- R9: If chip select rises before 16 bits have arrived, the partial frame has no effect: no byte is written, no pulse is raised and the bit count restarts. The reply still pending is shifted out again in the next full frame.
- R10: After reset every register byte reads as 0x00, and busy_o, capt_start_o and miso_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock from host, idles high |
| cs_n_i | input | 1 | Chip select, active low |
| mosi_i | input | 1 | Serial data from host |
| miso_o | output | 1 | Serial data to host |
| capt_done_i | input | 1 | Completion strobe from capture logic |
| capt_start_o | output | 1 | One-cycle capture-start pulse |
| busy_o | output | 1 | High from capture start until completion |

## Verification
Two events can hit the busy flag in the same system clock: the capture-start pulse that sets it and the completion strobe that clears it. The bench watches capt_start_o and raises capt_done_i exactly while the pulse is visible, so both reach the flag register at one clock edge. The bench then reads busy_o and expects it to be high, because setting takes priority. A separate completion strobe given later must bring busy_o low.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int FRAME_W = 16;
  localparam int ADDR_W  = 7;
  localparam int BYTE_W  = 8;

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [BYTE_W-1:0] data;
  } frame_t;
endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i) begin
      if (rst_i) chain_q <= {STAGES{RST_VAL[g]}};
      else       chain_q <= {chain_q[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/sreg_shifter.sv
module sreg_shifter
  import sreg_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               sclk_s_i,
  input  logic               cs_n_s_i,
  input  logic               din_s_i,
  input  logic [FRAME_W-1:0] reply_i,
  input  logic               reply_ld_i,
  output frame_t             frame_o,
  output logic               frame_done_o,
  output logic               sclk_fall_o,
  output logic               dout_o
);
  localparam int CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic               sclk_prev_q, cs_prev_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] rx_q, tx_q;
  logic               done_q, dout_q;
  frame_t             frame_q;
  logic               sclk_rise, cs_fall;

  assign sclk_rise   = sclk_s_i & ~sclk_prev_q;
  assign sclk_fall_o = ~sclk_s_i & sclk_prev_q;
  assign cs_fall     = ~cs_n_s_i & cs_prev_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sclk_prev_q <= 1'b1;
      cs_prev_q   <= 1'b1;
      cnt_q       <= '0;
      rx_q        <= '0;
      done_q      <= 1'b0;
      frame_q     <= '0;
    end else begin
      sclk_prev_q <= sclk_s_i;
      cs_prev_q   <= cs_n_s_i;
      done_q      <= 1'b0;
      if (cs_n_s_i) begin
        cnt_q <= '0;
      end else if (sclk_rise) begin
        rx_q <= {rx_q[FRAME_W-2:0], din_s_i};
        if (cnt_q == LAST) begin
          cnt_q   <= '0;
          done_q  <= 1'b1;
          frame_q <= frame_t'({rx_q[FRAME_W-2:0], din_s_i});
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      tx_q   <= '0;
      dout_q <= 1'b0;
    end else if (reply_ld_i || cs_fall) begin
      tx_q <= reply_i;
    end else if (sclk_fall_o && !cs_n_s_i) begin
      dout_q <= tx_q[FRAME_W-1];
      tx_q   <= {tx_q[FRAME_W-2:0], 1'b0};
    end
  end

  assign frame_o      = frame_q;
  assign frame_done_o = done_q;
  assign dout_o       = dout_q;
endmodule

// File: rtl/sreg_regfile.sv
module sreg_regfile
  import sreg_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 7'h3F,
  parameter int CMD_BIT = 3
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  frame_t             frame_i,
  input  logic               frame_done_i,
  output logic [FRAME_W-1:0] reply_o,
  output logic               reply_ld_o,
  output logic               capt_o
);
  localparam int NUM_BYTES = 2 * NUM_REGS;
  localparam int IDX_W = $clog2(NUM_BYTES);
  localparam logic [ADDR_W-1:0] NB_L = ADDR_W'(NUM_BYTES);

  logic [BYTE_W-1:0] mem_q [NUM_BYTES];
  logic [IDX_W-1:0]  idx, idx_lo, idx_hi;
  logic              in_range, wr_en, cmd_hit;

  assign in_range = frame_i.addr < NB_L;
  assign idx      = frame_i.addr[IDX_W-1:0];
  assign idx_lo   = {idx[IDX_W-1:1], 1'b0};
  assign idx_hi   = {idx[IDX_W-1:1], 1'b1};
  assign wr_en    = frame_done_i & frame_i.wr & in_range;
  assign cmd_hit  = frame_i.wr & (frame_i.addr == CMD_ADDR) & frame_i.data[CMD_BIT];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      for (int b = 0; b < NUM_BYTES; b++) mem_q[b] <= '0;
    end else if (wr_en) begin
      mem_q[idx] <= frame_i.data;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      reply_o    <= '0;
      reply_ld_o <= 1'b0;
      capt_o     <= 1'b0;
    end else begin
      reply_ld_o <= frame_done_i;
      capt_o     <= frame_done_i & cmd_hit;
      if (frame_done_i)
        reply_o <= (!frame_i.wr && in_range) ? {mem_q[idx_hi], mem_q[idx_lo]} : '0;
    end
  end
endmodule

// File: rtl/sreg_frontend.sv
module sreg_frontend
  import sreg_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter logic [6:0] CMD_ADDR = 7'h3F,
  parameter int CMD_BIT = 3
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic sclk_i,
  input  logic cs_n_i,
  input  logic mosi_i,
  output logic miso_o,
  input  logic capt_done_i,
  output logic capt_start_o,
  output logic busy_o
);
  logic [2:0]         sync_q;
  frame_t             frame_w;
  logic               frame_done_w, sclk_fall_w, reply_ld_w, capt_w;
  logic [FRAME_W-1:0] reply_w;
  logic               busy_q;

  sreg_sync #(.WIDTH(3), .STAGES(2), .RST_VAL(3'b011)) u_sync (
    .clk_i(clk_i), .rst_i(rst_i),
    .d_i({mosi_i, cs_n_i, sclk_i}), .q_o(sync_q)
  );

  sreg_shifter u_shift (
    .clk_i(clk_i), .rst_i(rst_i),
    .sclk_s_i(sync_q[0]), .cs_n_s_i(sync_q[1]), .din_s_i(sync_q[2]),
    .reply_i(reply_w), .reply_ld_i(reply_ld_w),
    .frame_o(frame_w), .frame_done_o(frame_done_w),
    .sclk_fall_o(sclk_fall_w), .dout_o(miso_o)
  );

  sreg_regfile #(.NUM_REGS(NUM_REGS), .CMD_ADDR(CMD_ADDR), .CMD_BIT(CMD_BIT)) u_regs (
    .clk_i(clk_i), .rst_i(rst_i),
    .frame_i(frame_w), .frame_done_i(frame_done_w),
    .reply_o(reply_w), .reply_ld_o(reply_ld_w), .capt_o(capt_w)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i)            busy_q <= 1'b0;
    else if (capt_w)      busy_q <= 1'b1;
    else if (capt_done_i) busy_q <= 1'b0;
  end

  assign capt_start_o = capt_w;
  assign busy_o       = busy_q;
endmodule

// File: rtl/sreg_frontend_chk.sv
module sreg_frontend_chk (
  input logic clk_i,
  input logic rst_i,
  input logic capt_start_o,
  input logic capt_done_i,
  input logic busy_o,
  input logic miso_o,
  input logic sclk_fall,
  input logic frame_done
);
  assert_pulse_single_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    capt_start_o |=> !capt_start_o);

  assert_pulse_after_frame_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    capt_start_o |-> $past(frame_done));

  assert_busy_set_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    capt_start_o |=> busy_o);

  assert_busy_clear_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy_o && capt_done_i && !capt_start_o) |=> !busy_o);

  assert_dout_on_fall_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(miso_o) |-> $past(sclk_fall));

  assert_reset_idle_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> (!capt_start_o && !busy_o && !miso_o));
endmodule

bind sreg_frontend sreg_frontend_chk u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .capt_start_o(capt_start_o),
  .capt_done_i(capt_done_i), .busy_o(busy_o), .miso_o(miso_o),
  .sclk_fall(sclk_fall_w), .frame_done(frame_done_w)
);

// File: tb/sreg_frontend_tb.sv
module sreg_frontend_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, sclk = 1'b1, cs_n = 1'b1, mosi = 1'b0;
  logic done_man = 1'b0, done_arm = 1'b0, capt_done = 1'b0;
  logic miso, capt_start, busy;
  int checks = 0, errors = 0;
  int rises = 0, hi_cycles = 0;
  logic start_prev = 1'b0;

  sreg_frontend u_dut (
    .clk_i(clk), .rst_i(rst), .sclk_i(sclk), .cs_n_i(cs_n), .mosi_i(mosi),
    .miso_o(miso), .capt_done_i(capt_done), .capt_start_o(capt_start), .busy_o(busy)
  );

  always @(negedge clk) begin
    capt_done <= done_man | (done_arm & capt_start);
    if (capt_start && !start_prev) rises++;
    if (capt_start) hi_cycles++;
    start_prev = capt_start;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic xfer(input logic [15:0] t, input int nb, output logic [15:0] r);
    r = '0;
    @(negedge clk) cs_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      sclk = 1'b0;
      mosi = t[15-i];
      repeat (10) @(negedge clk);
      r[15-i] = miso;
      sclk = 1'b1;
      repeat (10) @(negedge clk);
    end
    cs_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // {frame sent, reply expected in the same frame}
  // R1 framing, R2 byte writes, R3 reads, R4 streaming, R5 unmapped, R6 reply after write
  localparam logic [31:0] VEC [16] = '{
    32'h8034_0000, // R10 reset reply, write byte0
    32'h8112_0000, // R6 after write
    32'h8256_0000,
    32'h0000_0000, // R3 request reg0
    32'h02FF_1234, // R3 reply reg0, R4 new request reg1 with junk data
    32'h0500_0056, // R4 odd address of reg2 requested, reply reg1
    32'h83AB_0000, // R10 reg2 was cleared -> reply 0
    32'h0100_0000, // R6
    32'h2000_1234, // R3 odd address 1 returns reg0
    32'h3F00_0000, // R5 address 0x20
    32'h0200_0000, // R5 command address
    32'h8300_AB56, // R3 reg1
    32'h0200_0000, // R6
    32'h80FF_0056, // R2 high byte cleared, low kept
    32'h0000_0000, // R6
    32'h0000_12FF  // R2 byte0 replaced, byte1 kept
  };

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual running expected finished");
    finish_run();
  end

  initial begin
    logic [15:0] rx;
    int r0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10", "busy after reset", 32'(busy), 32'h0);
    chk("R10", "pulse after reset", 32'(capt_start), 32'h0);
    chk("R10", "miso after reset", 32'(miso), 32'h0);

    for (int v = 0; v < 16; v++) begin
      xfer(VEC[v][31:16], 16, rx);
      chk("R1/R2/R3/R4/R5/R6", $sformatf("vector %0d reply", v), 32'(rx), 32'(VEC[v][15:0]));
    end
    chk("R7", "no pulse from ordinary frames", 32'(rises), 32'h0);

    // R7 capture command
    xfer(16'hBF08, 16, rx);
    chk("R7", "pulse count after 0xBF08", 32'(rises), 32'h1);
    chk("R7", "pulse width", 32'(hi_cycles), 32'(rises));
    chk("R8", "busy after capture", 32'(busy), 32'h1);
    xfer(16'hBF00, 16, rx);
    xfer(16'hBE08, 16, rx);
    chk("R7", "no pulse from 0xBF00 or 0xBE08", 32'(rises), 32'h1);

    // R8 completion clears busy
    @(negedge clk) done_man = 1'b1;
    @(negedge clk) done_man = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8", "busy after done", 32'(busy), 32'h0);

    // R8 set and clear in the same cycle
    done_arm = 1'b1;
    xfer(16'hBF08, 16, rx);
    done_arm = 1'b0;
    chk("R8", "set wins over done", 32'(busy), 32'h1);
    chk("R7", "second capture pulse", 32'(rises), 32'h2);
    @(negedge clk) done_man = 1'b1;
    @(negedge clk) done_man = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8", "busy cleared after overlap", 32'(busy), 32'h0);

    // R9 aborted frames
    xfer(16'h0000, 16, rx);
    r0 = rises;
    xfer(16'h80AA, 12, rx);
    xfer(16'hBF08, 12, rx);
    chk("R9", "no pulse from partial frame", 32'(rises), 32'(r0));
    xfer(16'h0000, 16, rx);
    chk("R9", "pending reply resent", 32'(rx), 32'h12FF);
    xfer(16'h0000, 16, rx);
    chk("R9", "partial write discarded", 32'(rx), 32'h12FF);
    chk("R9", "busy untouched", 32'(busy), 32'h0);

    finish_run();
  end
endmodule